// File: doc/BRIEF.md
# Leak-Group Token Bucket Shaper

This block holds a bank of committed-rate token buckets, one for each shaping element. Each element has a rate and a burst limit. Buckets are not refilled by their own timers. Instead, each element is threaded onto a singly linked list that belongs to one of several leak groups. Each group has a programmable leak period. When the period expires, the group walks its list one element per clock. It starts at the group's first pointer and stops at the element whose link points to itself. Each visited element has its rate added to its bucket.

Groups are meant to be sized for different rate classes, from about 1 Gbit/s up to about 26 Gbit/s, by choosing their periods. A group can serve at most as many elements as it has clock cycles in its period. A frame scheduler subtracts frame lengths through the consume port and reads the per-element eligibility vector. Software edits list membership by writing links and first pointers. Before it relinks a group, it writes a zero period to that group, and it restores the period afterwards.

Top module: `lg_shaper`

## Requirements
- R1: After reset every period is zero, every first pointer is 0, every element links to itself, every rate, burst and bucket is zero, and no element is eligible.
- R2: A group with nonzero period P raises a leak every P cycles, counted from the cycle after the period is written. Writing zero stops its walk at once, drops any pending leak and restarts its count.
- R3: One cycle after a leak is taken, the walk loads the group's first pointer. It then visits one element per cycle, following links, and ends after visiting the element that links to itself.
- R4: Each visit adds the visited element's rate, in tokens, to that element's bucket at the same clock edge.
- R5: A bucket never exceeds its cap, which is the burst field times 64 tokens. A lowered burst clamps the bucket at the next edge.
- R6: A consume (valid, element index, length in tokens) subtracts the length at the next edge. If a refill lands on the same element in the same cycle, both are applied before the cap.
- R7: An element is eligible exactly when it is in use and its bucket, as a signed value, is zero or more.
- R8: An element whose rate and burst are both zero is unused. Its bucket is cleared at every edge, it is never eligible, and consumes aimed at it have no effect.
- R9: A leak that expires while the group's walk is still running is held. The next walk starts in the cycle after the current walk ends.
- R10: Config writes take effect at the next edge. cfg_kind 0 sets a group period, 1 sets a group first pointer, 2 sets an element link, and 3 sets an element's rate in data[11:0] and burst in data[19:12]. For kinds 0 and 1 the group is chosen by the low two bits of cfg_idx.
- R11: An element that several groups visit in the same cycle receives a single rate addition.
- R12: A bucket saturates at the most negative 16-bit value, -32768, instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_kind | input | 2 | Write target: 0 period, 1 first, 2 link, 3 rate/burst |
| cfg_idx | input | 3 | Element index, or group index in the low bits |
| cfg_data | input | 20 | Write data |
| cons_vld | input | 1 | Consume strobe |
| cons_idx | input | 3 | Element to charge |
| cons_len | input | 14 | Tokens to subtract |
| elig | output | 8 | Per-element eligibility |

## Verification
Refill from a list walk and a charge from the consume port can hit the same bucket in the same clock. The cap and the floor must then act on the combined result. The bench provokes this directly: it watches its own model of the walker and issues a consume on the element the walk is visiting in that cycle. Long random runs cover the same case with overlapping group walks. The judgement comes from a cycle model in the bench, built from the requirements, whose expected eligibility is compared with the output in every cycle.

// File: rtl/lgs_pkg.sv
package lgs_pkg;
  typedef enum logic [1:0] {
    CFG_PERIOD = 2'd0,
    CFG_FIRST  = 2'd1,
    CFG_LINK   = 2'd2,
    CFG_SHAPE  = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/lgs_walker.sv
module lgs_walker #(
  parameter int PER_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] cur_link,
  output logic             tick,
  output logic             pend,
  output logic             vld,
  output logic [IDX_W-1:0] idx
);
  logic [PER_W-1:0] cnt_q;
  logic             last_visit;

  assign tick       = (period != '0) && (cnt_q >= period - 1'b1);
  assign last_visit = vld && (cur_link == idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
      vld   <= 1'b0;
      idx   <= '0;
    end else if (period == '0) begin
      cnt_q <= '0;
      pend  <= 1'b0;
      vld   <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (vld) begin
        if (last_visit) vld <= 1'b0;
        else            idx <= cur_link;
        pend <= pend | tick;
      end else if (pend) begin
        vld  <= 1'b1;
        idx  <= first;
        pend <= tick;
      end else begin
        pend <= tick;
      end
    end
  end
endmodule

// File: rtl/lgs_bucket.sv
module lgs_bucket #(
  parameter int RATE_W      = 12,
  parameter int BURST_W     = 8,
  parameter int BURST_SHIFT = 6,
  parameter int LEN_W       = 14,
  parameter int BKT_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATE_W-1:0]  rate,
  input  logic [BURST_W-1:0] burst,
  input  logic               refill,
  input  logic               consume,
  input  logic [LEN_W-1:0]   len,
  output logic [BKT_W-1:0]   level,
  output logic               ok
);
  localparam int EW = BKT_W + 2;
  localparam logic signed [EW-1:0] FLOOR = {3'b111, {(BKT_W-1){1'b0}}};

  function automatic logic signed [EW-1:0] cap_of(input logic [BURST_W-1:0] b);
    logic [EW-1:0] w;
    w = '0;
    w[BURST_SHIFT +: BURST_W] = b;
    return $signed(w);
  endfunction

  function automatic logic [BKT_W-1:0] next_level(
    input logic [BKT_W-1:0]   cur,
    input logic [RATE_W-1:0]  add,
    input logic [LEN_W-1:0]   sub,
    input logic signed [EW-1:0] cap
  );
    logic signed [EW-1:0] s;
    s = $signed({{(EW-BKT_W){cur[BKT_W-1]}}, cur})
      + $signed({{(EW-RATE_W){1'b0}}, add})
      - $signed({{(EW-LEN_W){1'b0}}, sub});
    if (s > cap)        s = cap;
    else if (s < FLOOR) s = FLOOR;
    return s[BKT_W-1:0];
  endfunction

  logic unused_se;
  assign unused_se = (rate == '0) && (burst == '0);
  assign ok        = !unused_se && !level[BKT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || unused_se) level <= '0;
    else level <= next_level(level,
                             refill  ? rate : '0,
                             consume ? len  : '0,
                             cap_of(burst));
  end
endmodule

// File: rtl/lg_shaper.sv
module lg_shaper #(
  parameter int NUM_SE      = 8,
  parameter int NUM_GRP     = 4,
  parameter int PER_W       = 16,
  parameter int RATE_W      = 12,
  parameter int BURST_W     = 8,
  parameter int BURST_SHIFT = 6,
  parameter int LEN_W       = 14,
  parameter int BKT_W       = 16,
  localparam int IDX_W  = $clog2(NUM_SE),
  localparam int CFG_W  = (PER_W > RATE_W + BURST_W) ? PER_W : RATE_W + BURST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              cons_vld,
  input  logic [IDX_W-1:0]  cons_idx,
  input  logic [LEN_W-1:0]  cons_len,
  output logic [NUM_SE-1:0] elig
);
  import lgs_pkg::*;
  localparam int GIDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic [NUM_GRP-1:0][PER_W-1:0]  period_q;
  logic [NUM_GRP-1:0][IDX_W-1:0]  first_q;
  logic [NUM_SE-1:0][IDX_W-1:0]   link_q;
  logic [NUM_SE-1:0][RATE_W-1:0]  rate_q;
  logic [NUM_SE-1:0][BURST_W-1:0] burst_q;
  logic [NUM_SE-1:0][BKT_W-1:0]   bucket_q;

  logic [NUM_GRP-1:0]             grp_tick;
  logic [NUM_GRP-1:0]             grp_pend;
  logic [NUM_GRP-1:0]             visit_vld;
  logic [NUM_GRP-1:0][IDX_W-1:0]  visit_idx;
  logic [NUM_SE-1:0]              refill_hit;

  cfg_kind_e         kind;
  logic [GIDX_W-1:0] grp_sel;
  assign kind    = cfg_kind_e'(cfg_kind);
  assign grp_sel = cfg_idx[GIDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        period_q[g] <= '0;
        first_q[g]  <= '0;
      end
      for (int i = 0; i < NUM_SE; i++) begin
        link_q[i]  <= IDX_W'(i);
        rate_q[i]  <= '0;
        burst_q[i] <= '0;
      end
    end else if (cfg_we) begin
      unique case (kind)
        CFG_PERIOD: period_q[grp_sel] <= cfg_data[PER_W-1:0];
        CFG_FIRST:  first_q[grp_sel]  <= cfg_data[IDX_W-1:0];
        CFG_LINK:   link_q[cfg_idx]   <= cfg_data[IDX_W-1:0];
        CFG_SHAPE: begin
          rate_q[cfg_idx]  <= cfg_data[RATE_W-1:0];
          burst_q[cfg_idx] <= cfg_data[RATE_W +: BURST_W];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    lgs_walker #(.PER_W(PER_W), .IDX_W(IDX_W)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .period   (period_q[g]),
      .first    (first_q[g]),
      .cur_link (link_q[visit_idx[g]]),
      .tick     (grp_tick[g]),
      .pend     (grp_pend[g]),
      .vld      (visit_vld[g]),
      .idx      (visit_idx[g])
    );
  end

  always_comb begin
    refill_hit = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (visit_vld[g]) refill_hit[visit_idx[g]] = 1'b1;
  end

  for (genvar i = 0; i < NUM_SE; i++) begin : g_se
    lgs_bucket #(
      .RATE_W(RATE_W), .BURST_W(BURST_W), .BURST_SHIFT(BURST_SHIFT),
      .LEN_W(LEN_W), .BKT_W(BKT_W)
    ) u_bkt (
      .clk     (clk),
      .rst_n   (rst_n),
      .rate    (rate_q[i]),
      .burst   (burst_q[i]),
      .refill  (refill_hit[i]),
      .consume (cons_vld && (cons_idx == IDX_W'(i))),
      .len     (cons_len),
      .level   (bucket_q[i]),
      .ok      (elig[i])
    );
  end
endmodule

// File: rtl/lg_shaper_chk.sv
module lg_shaper_chk #(
  parameter int NUM_SE      = 8,
  parameter int NUM_GRP     = 4,
  parameter int PER_W       = 16,
  parameter int RATE_W      = 12,
  parameter int BURST_W     = 8,
  parameter int BURST_SHIFT = 6,
  parameter int BKT_W       = 16,
  parameter int IDX_W       = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_GRP-1:0][PER_W-1:0]    period_q,
  input logic [NUM_SE-1:0][IDX_W-1:0]     link_q,
  input logic [NUM_SE-1:0][RATE_W-1:0]    rate_q,
  input logic [NUM_SE-1:0][BURST_W-1:0]   burst_q,
  input logic [NUM_SE-1:0][BKT_W-1:0]     bucket_q,
  input logic [NUM_GRP-1:0]               grp_tick,
  input logic [NUM_GRP-1:0]               grp_pend,
  input logic [NUM_GRP-1:0]               visit_vld,
  input logic [NUM_GRP-1:0][IDX_W-1:0]    visit_idx
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_g
    a_r2_off_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
      period_q[g] == '0 |=> !visit_vld[g]);
    a_r3_follow_link: assert property (@(posedge clk) disable iff (!rst_n)
      visit_vld[g] && period_q[g] != '0 && link_q[visit_idx[g]] != visit_idx[g]
      |=> visit_vld[g] && visit_idx[g] == $past(link_q[visit_idx[g]]));
    a_r3_stop_at_self: assert property (@(posedge clk) disable iff (!rst_n)
      visit_vld[g] && period_q[g] != '0 && link_q[visit_idx[g]] == visit_idx[g]
      |=> !visit_vld[g]);
    a_r9_leak_held: assert property (@(posedge clk) disable iff (!rst_n)
      grp_tick[g] |=> grp_pend[g]);
  end
  for (genvar i = 0; i < NUM_SE; i++) begin : g_s
    a_r5_under_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(burst_q[i]) |->
        int'($signed(bucket_q[i])) <= int'(burst_q[i]) * (1 << BURST_SHIFT));
    a_r8_unused_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rate_q[i] == '0 && burst_q[i] == '0) |-> bucket_q[i] == '0);
  end
endmodule

bind lg_shaper lg_shaper_chk #(
  .NUM_SE(NUM_SE), .NUM_GRP(NUM_GRP), .PER_W(PER_W), .RATE_W(RATE_W),
  .BURST_W(BURST_W), .BURST_SHIFT(BURST_SHIFT), .BKT_W(BKT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .period_q(period_q), .link_q(link_q),
  .rate_q(rate_q), .burst_q(burst_q), .bucket_q(bucket_q),
  .grp_tick(grp_tick), .grp_pend(grp_pend),
  .visit_vld(visit_vld), .visit_idx(visit_idx)
);

// File: tb/lg_shaper_tb.sv
module lg_shaper_tb;
  localparam int NS = 8;
  localparam int NG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [2:0]  cfg_idx = '0;
  logic [19:0] cfg_data = '0;
  logic        cons_vld = 1'b0;
  logic [2:0]  cons_idx = '0;
  logic [13:0] cons_len = '0;
  logic [7:0]  elig;

  lg_shaper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .cons_vld(cons_vld),
    .cons_idx(cons_idx), .cons_len(cons_len), .elig(elig)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_per[NG], m_first[NG], m_cnt[NG], m_cur[NG];
  bit m_pend[NG], m_act[NG];
  int m_link[NS], m_rate[NS], m_burst[NS], m_bkt[NS];

  function automatic bit in_use(int i);
    return (m_rate[i] != 0) || (m_burst[i] != 0);
  endfunction

  function automatic logic [7:0] want_elig();
    logic [7:0] v;
    for (int i = 0; i < NS; i++) v[i] = in_use(i) && (m_bkt[i] >= 0);
    return v;
  endfunction

  task automatic check(string req);
    logic [7:0] e;
    e = want_elig();
    checks++;
    if (elig !== e) begin
      errors++;
      $display("FAIL %s: elig=%b expected %b at %0t", req, elig, e, $time);
    end
  endtask

  task automatic model_step(bit we, int kind, int idx, int data, bit cv, int ci, int cl);
    bit gets[NS];
    int s, top;
    bit t;
    for (int i = 0; i < NS; i++) gets[i] = 0;
    for (int g = 0; g < NG; g++) if (m_act[g]) gets[m_cur[g]] = 1;
    for (int i = 0; i < NS; i++) begin
      if (!in_use(i)) m_bkt[i] = 0;
      else begin
        s = m_bkt[i];
        if (gets[i]) s += m_rate[i];
        if (cv && ci == i) s -= cl;
        top = m_burst[i] * 64;
        m_bkt[i] = (s > top) ? top : ((s < -32768) ? -32768 : s);
      end
    end
    for (int g = 0; g < NG; g++) begin
      if (m_per[g] == 0) begin
        m_cnt[g] = 0; m_pend[g] = 0; m_act[g] = 0;
      end else begin
        t = (m_cnt[g] + 1 >= m_per[g]);
        m_cnt[g] = t ? 0 : m_cnt[g] + 1;
        if (m_act[g]) begin
          if (m_link[m_cur[g]] == m_cur[g]) m_act[g] = 0;
          else m_cur[g] = m_link[m_cur[g]];
          m_pend[g] = m_pend[g] | t;
        end else if (m_pend[g]) begin
          m_act[g] = 1; m_cur[g] = m_first[g]; m_pend[g] = t;
        end else m_pend[g] = t;
      end
    end
    if (we) begin
      case (kind)
        0: m_per[idx % 4] = data & 16'hFFFF;
        1: m_first[idx % 4] = data & 7;
        2: m_link[idx] = data & 7;
        default: begin m_rate[idx] = data & 12'hFFF; m_burst[idx] = (data >> 12) & 8'hFF; end
      endcase
    end
  endtask

  task automatic cyc(bit we, int kind, int idx, int data, bit cv, int ci, int cl, string req);
    @(negedge clk);
    check(req);
    cfg_we = we; cfg_kind = 2'(kind); cfg_idx = 3'(idx); cfg_data = 20'(data);
    cons_vld = cv; cons_idx = 3'(ci); cons_len = 14'(cl);
    model_step(we, kind, idx, data, cv, ci, cl);
  endtask

  task automatic wr(int kind, int idx, int data, string req);
    cyc(1, kind, idx, data, 0, 0, 0, req);
  endtask

  task automatic idle(int n, string req);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, req);
  endtask

  function automatic int shape(int rate, int burst);
    return (burst << 12) | rate;
  endfunction

  initial begin
    int unsigned seed;
    int guard;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int g = 0; g < NG; g++) begin
      m_per[g] = 0; m_first[g] = 0; m_cnt[g] = 0; m_cur[g] = 0; m_pend[g] = 0; m_act[g] = 0;
    end
    for (int i = 0; i < NS; i++) begin
      m_link[i] = i; m_rate[i] = 0; m_burst[i] = 0; m_bkt[i] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, nothing eligible
    idle(3, "R1");
    checks++;
    if (elig !== 8'h00) begin errors++; $display("FAIL R1: elig=%b expected 00000000", elig); end

    // R10: programming through all four write kinds
    wr(3, 0, shape(40, 2), "R10");   wr(3, 1, shape(100, 4), "R10");
    wr(3, 2, shape(7, 1), "R10");    wr(3, 3, shape(300, 20), "R10");
    wr(3, 4, shape(1, 1), "R10");    wr(3, 5, shape(50, 3), "R10");
    wr(3, 6, shape(20, 2), "R10");
    wr(2, 0, 1, "R10"); wr(2, 1, 2, "R10");
    wr(2, 3, 4, "R10"); wr(2, 5, 6, "R10");
    wr(1, 0, 0, "R10"); wr(1, 1, 3, "R10"); wr(1, 7, 5, "R10");
    wr(0, 0, 9, "R10"); wr(0, 1, 13, "R10");
    idle(40, "R4");
    idle(40, "R3");
    // R9: group 3 period 2 is shorter than its walk
    wr(0, 3, 2, "R9");
    idle(60, "R9");

    // R7: random consumes against refills
    for (int k = 0; k < 2000; k++) begin
      if (($urandom % 2) == 0) cyc(0, 0, 0, 0, 1, $urandom % 8, $urandom % 300, "R7");
      else idle(1, "R7");
    end

    // R6: consume on element 1 in the very cycle group 0 visits it
    for (int rep = 0; rep < 3; rep++) begin
      guard = 0;
      while (!(m_act[0] && m_cur[0] == 1) && guard < 100) begin idle(1, "R6"); guard++; end
      cyc(0, 0, 0, 0, 1, 1, 90 + rep * 60, "R6");
      idle(2, "R6");
    end

    // R12: drive element 4 far negative
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 1, 4, 16383, "R12");
    idle(5, "R12");

    // R5: lowering the burst clamps the bucket
    idle(60, "R5");
    wr(3, 3, shape(300, 1), "R5");
    idle(40, "R5");

    // R8: element 6 made unused; consumes on it are ignored
    wr(3, 6, 0, "R8");
    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0, 1, 6, 500, "R8");
    idle(10, "R8");

    // R2: disable group 0 mid walk, relink, re-enable
    guard = 0;
    while (!m_act[0] && guard < 100) begin idle(1, "R2"); guard++; end
    wr(0, 0, 0, "R2");
    idle(20, "R2");
    wr(2, 2, 0, "R2"); wr(2, 0, 0, "R2"); wr(1, 0, 2, "R2");
    wr(0, 0, 5, "R2");
    idle(50, "R2");

    // R11: element 0 is the tail of two lists at once
    wr(0, 1, 0, "R11");
    wr(2, 4, 0, "R11");
    wr(0, 1, 6, "R11");
    for (int k = 0; k < 1500; k++) begin
      if (($urandom % 3) == 0) cyc(0, 0, 0, 0, 1, $urandom % 8, $urandom % 200, "R11");
      else idle(1, "R11");
    end
    idle(2, "R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=still running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule